// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one programmable performance-monitoring counter. Every clock cycle it samples a small occurrence count from each of two hardware threads, the current privilege level and the identity of the local thread. It turns that sample into an increment according to its control inputs, and it adds the increment to a wide accumulator. The controls are: a global enable, separate user-level and kernel-level enables, an invert flag, an edge flag, a cross-thread flag and an 8-bit threshold.

Software can preset the accumulator through a write port, and a sticky flag records wrap-around. Selecting which event feeds the inputs is done elsewhere. The event inputs are sampled every cycle with no handshake, so the block never applies back-pressure and drops nothing. A cycle's contribution appears on `count` after the next rising clock edge.

The qualification order is fixed:
1. Thread selection or summing.
2. Privilege filtering.
3. Threshold compare.
4. Inversion.
5. Edge detection.

Top module: `perf_event_counter`

## Requirements
- R1: After reset `count` is 0 and `ovf` is 0.
- R2: Privilege level 0 is counted only when `kern_en` is 1. Levels 1, 2 and 3 are counted only when `user_en` is 1. A cycle at a filtered-out level counts as an occurrence count of zero.
- R3: When `any_thread` is 1, the occurrence count is `evt_t0 + evt_t1`. Otherwise it is `evt_t0` when `local_tid` is 0 and `evt_t1` when `local_tid` is 1.
- R4: With a nonzero `thresh` and `invert` at 0, the counter adds 1 in each cycle whose filtered occurrence count is greater than or equal to `thresh`, and adds 0 otherwise.
- R5: With `thresh` equal to 0 and `edge_det` at 0, the counter adds the filtered occurrence count itself, and `invert` has no effect.
- R6: With a nonzero `thresh` and `invert` at 1, the counter adds 1 in each cycle where the count is below `thresh`.
- R7: With `edge_det` at 1 and a nonzero `thresh`, the counter adds 1 only when the qualified condition is true in this cycle and was false in the previous cycle. The remembered previous state is false after reset and while `enable` is 0.
- R8: With `edge_det` at 1 and `thresh` equal to 0, the counter never increments.
- R9: When the counter wraps past all ones it keeps the wrapped value and sets `ovf`. `ovf` stays set until a software write.
- R10: A write (`wr_en` at 1) loads `wr_data` into `count` at the next edge and clears `ovf`. A write overrides any increment in the same cycle.
- R11: While `enable` is 0 and no write occurs, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_t0 | input | EVT_W | Occurrences this cycle, thread 0 |
| evt_t1 | input | EVT_W | Occurrences this cycle, thread 1 |
| local_tid | input | 1 | Which thread is local (0 or 1) |
| priv | input | 2 | Current privilege level, 0 is kernel |
| enable | input | 1 | Global counting enable |
| user_en | input | 1 | Count at levels 1 to 3 |
| kern_en | input | 1 | Count at level 0 |
| invert | input | 1 | Count cycles failing the threshold |
| edge_det | input | 1 | Count only rising qualified condition |
| any_thread | input | 1 | Sum both threads |
| thresh | input | 8 | Threshold, 0 to 255 |
| wr_en | input | 1 | Software preset strobe |
| wr_data | input | CNT_W | Preset value |
| count | output | CNT_W | Accumulated count |
| ovf | output | 1 | Sticky wrap flag |

## Verification
Two functions can fall in the same cycle: a software write and an increment, which may itself be the wrapping increment. The bench issues writes while events are flowing and the qualifiers allow counting. It also presets the counter just below all ones so that the next increments wrap. A reference model in the bench treats the write as overriding the increment and the wrap, and the bench compares `count` and `ovf` with that model after every edge.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef struct packed {
    logic       enable;
    logic       any_thread;
    logic       edge_det;
    logic       invert;
    logic       user_en;
    logic       kern_en;
    logic [7:0] thresh;
  } pec_ctrl_t;

  localparam int unsigned THR_W = 8;
endpackage

// File: rtl/pec_combine.sv
// Thread selection or summing, followed by the privilege filter.
module pec_combine #(
  parameter int unsigned EVT_W = 4
) (
  input  logic [EVT_W-1:0] evt_t0,
  input  logic [EVT_W-1:0] evt_t1,
  input  logic             local_tid,
  input  logic [1:0]       priv,
  input  pec_pkg::pec_ctrl_t ctrl,
  output logic [EVT_W:0]   occ
);
  logic [EVT_W:0] picked;
  logic           priv_ok;

  always_comb begin
    if (ctrl.any_thread)
      picked = {1'b0, evt_t0} + {1'b0, evt_t1};
    else if (local_tid)
      picked = {1'b0, evt_t1};
    else
      picked = {1'b0, evt_t0};

    // Level 0 is kernel; levels 1 to 3 are user.
    priv_ok = (priv == 2'd0) ? ctrl.kern_en : ctrl.user_en;
    occ = priv_ok ? picked : '0;
  end
endmodule

// File: rtl/pec_qualify.sv
// Threshold compare, inversion and edge detection; produces this cycle's increment.
module pec_qualify #(
  parameter int unsigned EVT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_W:0]     occ,
  input  pec_pkg::pec_ctrl_t ctrl,
  output logic [EVT_W:0]     inc
);
  localparam int unsigned OCC_W = EVT_W + 1;
  localparam int unsigned CMP_W = (OCC_W > pec_pkg::THR_W) ? OCC_W : pec_pkg::THR_W;

  logic             thr_zero;
  logic             meets;
  logic             qual;
  logic             prev_q;
  logic [CMP_W-1:0] occ_x;
  logic [CMP_W-1:0] thr_x;

  always_comb begin
    occ_x    = CMP_W'(occ);
    thr_x    = CMP_W'(ctrl.thresh);
    thr_zero = (ctrl.thresh == '0);
    meets    = (occ_x >= thr_x);
    qual     = meets ^ ctrl.invert;
    inc      = '0;
    if (ctrl.enable) begin
      if (thr_zero)
        inc = ctrl.edge_det ? '0 : occ;                 // edge with zero threshold is invalid
      else if (ctrl.edge_det)
        inc = OCC_W'(qual & ~prev_q);
      else
        inc = OCC_W'(qual);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      prev_q <= 1'b0;
    else if (!ctrl.enable || thr_zero)
      prev_q <= 1'b0;
    else
      prev_q <= qual;
  end
endmodule

// File: rtl/pec_accum.sv
// Wide accumulator with software preset and sticky wrap flag.
module pec_accum #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [CNT_W:0] sum;

  always_comb sum = {1'b0, count} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (wr_en) begin
      count <= wr_data;
      ovf   <= 1'b0;
    end else begin
      count <= sum[CNT_W-1:0];
      if (sum[CNT_W]) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int unsigned EVT_W = 4,
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_t0,
  input  logic [EVT_W-1:0] evt_t1,
  input  logic             local_tid,
  input  logic [1:0]       priv,
  input  logic             enable,
  input  logic             user_en,
  input  logic             kern_en,
  input  logic             invert,
  input  logic             edge_det,
  input  logic             any_thread,
  input  logic [7:0]       thresh,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int unsigned OCC_W = EVT_W + 1;

  pec_pkg::pec_ctrl_t ctrl;
  logic [OCC_W-1:0]   occ;
  logic [OCC_W-1:0]   inc;

  always_comb begin
    ctrl.enable     = enable;
    ctrl.any_thread = any_thread;
    ctrl.edge_det   = edge_det;
    ctrl.invert     = invert;
    ctrl.user_en    = user_en;
    ctrl.kern_en    = kern_en;
    ctrl.thresh     = thresh;
  end

  pec_combine #(.EVT_W(EVT_W)) u_combine (
    .evt_t0(evt_t0), .evt_t1(evt_t1), .local_tid(local_tid),
    .priv(priv), .ctrl(ctrl), .occ(occ)
  );

  pec_qualify #(.EVT_W(EVT_W)) u_qualify (
    .clk(clk), .rst_n(rst_n), .occ(occ), .ctrl(ctrl), .inc(inc)
  );

  pec_accum #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .inc(inc), .count(count), .ovf(ovf)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int unsigned CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             edge_det,
  input logic [7:0]       thresh,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             ovf
);
  // R10: a write loads the value and clears the flag.
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)) && !ovf);

  // R9: the wrap flag is sticky until a write.
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_en) |=> ovf);

  // R8: edge with zero threshold never increments.
  a_r8_edge_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && edge_det && thresh == 8'd0 && !wr_en) |=> $stable(count));

  // R11: disabled counter holds.
  a_r11_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en) |=> $stable(count));

  // R4: with a nonzero threshold at most one per cycle.
  a_r4_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != 8'd0 && !wr_en && count != {CNT_W{1'b1}}) |=> (count - $past(count)) <= CNT_W'(1));
endmodule

bind perf_event_counter pec_checker #(.CNT_W(CNT_W)) u_pec_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .edge_det(edge_det), .thresh(thresh),
  .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf(ovf)
);

// File: tb/test_perf_event_counter.sv
module test_perf_event_counter;
  localparam int unsigned EVT_W = 4;
  localparam int unsigned CNT_W = 48;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [EVT_W-1:0] evt_t0 = '0, evt_t1 = '0;
  logic             local_tid = 1'b0;
  logic [1:0]       priv = 2'd0;
  logic             enable = 1'b0, user_en = 1'b0, kern_en = 1'b0;
  logic             invert = 1'b0, edge_det = 1'b0, any_thread = 1'b0;
  logic [7:0]       thresh = 8'd0;
  logic             wr_en = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] count;
  logic             ovf;

  int checks = 0;
  int errors = 0;
  string req = "R1";
  logic [CNT_W-1:0] m_cnt = '0;
  logic             m_ovf = 1'b0;
  logic             m_prev = 1'b0;

  always #10 clk = ~clk;

  perf_event_counter #(.EVT_W(EVT_W), .CNT_W(CNT_W)) i_perf_event_counter (
    .clk(clk), .rst_n(rst_n), .evt_t0(evt_t0), .evt_t1(evt_t1), .local_tid(local_tid),
    .priv(priv), .enable(enable), .user_en(user_en), .kern_en(kern_en), .invert(invert),
    .edge_det(edge_det), .any_thread(any_thread), .thresh(thresh), .wr_en(wr_en),
    .wr_data(wr_data), .count(count), .ovf(ovf)
  );

  function automatic int occ_of();
    int o;
    o = any_thread ? (int'(evt_t0) + int'(evt_t1)) : (local_tid ? int'(evt_t1) : int'(evt_t0));
    if (!((priv == 2'd0 && kern_en) || (priv != 2'd0 && user_en))) o = 0;
    return o;
  endfunction

  task automatic model_step();
    int o, inc;
    logic q, pn;
    logic [CNT_W:0] s;
    o = occ_of(); inc = 0; pn = 1'b0;
    if (enable) begin
      if (thresh == 8'd0) inc = edge_det ? 0 : o;
      else begin
        q = (o >= int'(thresh)) ^ invert;
        inc = edge_det ? int'(q && !m_prev) : int'(q);
        pn = q;
      end
    end
    m_prev = pn;
    if (wr_en) begin m_cnt = wr_data; m_ovf = 1'b0; end
    else begin
      s = {1'b0, m_cnt} + (CNT_W+1)'(inc);
      m_cnt = s[CNT_W-1:0];
      if (s[CNT_W]) m_ovf = 1'b1;
    end
  endtask

  task automatic compare();
    checks++;
    if (count !== m_cnt || ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s: count=%h ovf=%b expected count=%h ovf=%b", req, count, ovf, m_cnt, m_ovf);
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic set_cfg(input logic en, input logic ue, input logic ke, input logic inv,
                         input logic ed, input logic anyt, input logic [7:0] th);
    enable = en; user_en = ue; kern_en = ke; invert = inv; edge_det = ed; any_thread = anyt; thresh = th;
  endtask

  task automatic rand_run(input int n, input logic vary_priv);
    for (int i = 0; i < n; i++) begin
      evt_t0 = EVT_W'($urandom_range(0, 15));
      evt_t1 = EVT_W'($urandom_range(0, 15));
      local_tid = 1'($urandom_range(0, 1));
      if (vary_priv) priv = 2'($urandom_range(0, 3));
      cyc();
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_n = 1'b1;

    req = "R5"; set_cfg(1, 1, 1, 0, 0, 0, 8'd0); rand_run(40, 1);
    req = "R5"; invert = 1'b1; rand_run(40, 1);
    req = "R2"; set_cfg(1, 1, 0, 0, 0, 0, 8'd0); rand_run(60, 1);
    req = "R2"; set_cfg(1, 0, 1, 0, 0, 0, 8'd0); rand_run(60, 1);
    req = "R2"; set_cfg(1, 0, 0, 0, 0, 0, 8'd0); rand_run(20, 1);
    req = "R3"; set_cfg(1, 1, 1, 0, 0, 1, 8'd0); rand_run(60, 1);
    req = "R3"; set_cfg(1, 1, 1, 0, 0, 1, 8'd20); rand_run(60, 1);
    req = "R4"; set_cfg(1, 1, 1, 0, 0, 0, 8'd8); rand_run(80, 1);
    req = "R4"; set_cfg(1, 1, 1, 0, 0, 0, 8'd255); rand_run(20, 1);
    req = "R6"; set_cfg(1, 1, 0, 1, 0, 0, 8'd6); rand_run(80, 1);
    req = "R7"; set_cfg(1, 1, 1, 0, 1, 1, 8'd12); rand_run(120, 1);
    req = "R7"; set_cfg(1, 1, 1, 1, 1, 0, 8'd4); rand_run(80, 1);
    // R7 directed: condition held true, disable, re-enable -> a fresh edge counts
    req = "R7"; set_cfg(1, 1, 1, 0, 1, 0, 8'd1); priv = 2'd3; local_tid = 1'b0; evt_t0 = 4'd5;
    cyc(); cyc(); enable = 1'b0; cyc(); enable = 1'b1; cyc(); cyc();
    req = "R8"; set_cfg(1, 1, 1, 0, 1, 1, 8'd0); rand_run(40, 1);
    req = "R11"; set_cfg(0, 1, 1, 0, 0, 1, 8'd0); rand_run(40, 1);
    // R9: preset near all ones so the next increment wraps
    req = "R9"; set_cfg(1, 1, 1, 0, 0, 0, 8'd0); priv = 2'd1; local_tid = 1'b0; evt_t0 = 4'd0;
    wr_en = 1'b1; wr_data = {CNT_W{1'b1}} - CNT_W'(1); cyc(); wr_en = 1'b0;
    evt_t0 = 4'd5; cyc(); evt_t0 = 4'd0; cyc(); cyc();
    req = "R9"; rand_run(20, 1);
    // R10: write with a live increment and a pending wrap
    req = "R10"; wr_en = 1'b1; wr_data = {CNT_W{1'b1}}; evt_t0 = 4'd9; cyc();
    wr_data = 48'h0000_1234_5678; cyc(); wr_en = 1'b0; cyc();
    for (int k = 0; k < 60; k++) begin
      req = "R10";
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = ($urandom_range(0, 1) == 1) ? {CNT_W{1'b1}} - CNT_W'($urandom_range(0, 20))
                                            : CNT_W'($urandom());
      set_cfg(1, 1, 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              8'($urandom_range(0, 3)));
      rand_run(1, 1);
    end
    wr_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule